// File: doc/BRIEF.md
# Programmable UART Frame Engine

This block sends and receives asynchronous serial characters. A line-control word chosen at run time sets the character format: length, stop period, parity mode and a forced-break control. An integer divider sets the bit period. The transmit side accepts one byte at a time over a valid/ready handshake and shifts it out LSB first on the TX pin. The receive side watches the RX pin through a synchronizer. It returns each character with parity, framing and break flags.

The format and the bit period are captured when a character starts, so changing the control inputs never corrupts a character in flight. The one exception is the forced-break control, which acts on the TX pin at once. A transmitter-empty status tells the host when the line is truly quiet. It is used, for example, before turning off a line driver.

Top module: `uart_frame_engine`

## Requirements
- R1: Line-control bits [1:0] set the character length: 0 → 5 bits, 1 → 6, 2 → 7, 3 → 8. Data goes out and is collected LSB first, and received characters are zero-extended to 8 bits.
- R2: When line-control bit 2 is set, the transmit stop period is 2 bit periods. For 5-bit characters it is 1.5 bit periods instead. When the bit is clear, the stop period is 1 bit period.
- R3: Line-control bit 3 adds a parity bit after the data. Bit 4 = 1 selects even parity and 0 selects odd. The receiver flags a parity error when the received parity bit differs from the expected one.
- R4: When line-control bit 5 (stick) is set together with bit 3, the parity bit is a constant: 0 if bit 4 is 1, and 1 if bit 4 is 0. This applies both to sending and to checking.
- R5: While line-control bit 6 is set, TX is driven low.
- R6: One bit period is the divider input plus 2 clock cycles. A whole transmit frame lasts (div+2)·(1+length+parity) clock cycles plus the stop period.
- R7: tx_empty_o is high only when the transmit shifter is idle. It falls in the cycle after a handshake and rises again exactly one frame time later.
- R8: tx_ready_o is high only when the transmitter is idle. A byte is accepted on a clock edge where both tx_valid_i and tx_ready_o are high.
- R9: The receiver samples every bit at its midpoint, timed from the detected start edge. A start bit that reads high at its midpoint is discarded without producing a character.
- R10: A character whose first stop bit samples low is reported with rx_ferr_o set.
- R11: A character that reads low at every sample point from the start bit through the first stop bit is reported with rx_brk_o and rx_ferr_o set and data 0.
- R12: rx_valid_o is a single-cycle pulse for each received character, and the data and flags are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lcr_i | input | 7 | Line control: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] stick, [6] force break |
| div_i | input | DIV_W | Baud divider; bit period is div_i+2 clocks |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte available |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| txd_o | output | 1 | Serial transmit line |
| tx_empty_o | output | 1 | Transmit shifter idle |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| rx_data_o | output | 8 | Received character |
| rx_valid_o | output | 1 | Received character strobe |
| rx_perr_o | output | 1 | Parity error on this character |
| rx_ferr_o | output | 1 | Framing error on this character |
| rx_brk_o | output | 1 | Break detected on this character |

## Verification
The transmitter is driven with 8-bit no-parity, 5-bit 1.5-stop at an odd bit period, 7-bit even parity with two stops, and 6-bit stick parity in both polarities. Measuring the cycles from handshake to empty separates the three stop lengths and shows whether the divider offset is applied. The receiver gets clean characters in several formats. It also gets characters with a flipped parity bit, a low stop bit, a held-low line and a short start glitch. Each of these must raise exactly its own flag, or no strobe at all, and a clean character must follow the glitch intact.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
   } fe_state_t;

   // keep only the low 5..8 bits of a character
   function automatic logic [7:0] fe_mask(input logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

   // parity bit for a character under the given mode
   function automatic logic fe_parity(input logic stick, input logic even,
                                      input logic [1:0] len, input logic [7:0] d);
      logic ones;
      ones = ^(d & fe_mask(len));
      if (stick) return ~even;
      return even ? ones : ~ones;
   endfunction

endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) chain_q[0] <= 1'b1;
            else         chain_q[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) chain_q[g] <= 1'b1;
            else         chain_q[g] <= chain_q[g-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
   import uart_fe_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       len_i,
   input  logic             long_stop_i,
   input  logic             par_en_i,
   input  logic             even_i,
   input  logic             stick_i,
   input  logic             brk_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [7:0]       data_i,
   input  logic             valid_i,
   output logic             ready_o,
   output logic             txd_o,
   output logic             empty_o
);
   localparam int CNT_W = DIV_W + 2;

   fe_state_t        st_q;
   logic [CNT_W-1:0] cnt_q, period_q, stop_len, lim;
   logic [7:0]       sh_q;
   logic [2:0]       bit_q;
   logic [1:0]       len_q;
   logic             long_q, par_en_q, par_q, line;

   always_comb begin
      if (!long_q)           stop_len = period_q;
      else if (len_q == 2'd0) stop_len = period_q + (period_q >> 1);
      else                   stop_len = period_q << 1;
      lim = (st_q == ST_STOP) ? stop_len : period_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         period_q <= CNT_W'(2);
         sh_q     <= '0;
         bit_q    <= '0;
         len_q    <= '0;
         long_q   <= 1'b0;
         par_en_q <= 1'b0;
         par_q    <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         if (valid_i) begin
            sh_q     <= data_i;
            len_q    <= len_i;
            long_q   <= long_stop_i;
            par_en_q <= par_en_i;
            par_q    <= fe_parity(stick_i, even_i, len_i, data_i);
            period_q <= {2'b00, div_i} + CNT_W'(2);
            cnt_q    <= '0;
            bit_q    <= '0;
            st_q     <= ST_START;
         end
      end else if (cnt_q == lim - CNT_W'(1)) begin
         cnt_q <= '0;
         unique case (st_q)
            ST_START: st_q <= ST_DATA;
            ST_DATA: begin
               sh_q <= sh_q >> 1;
               if (bit_q == {1'b1, len_q}) st_q <= par_en_q ? ST_PAR : ST_STOP;
               else                        bit_q <= bit_q + 3'd1;
            end
            ST_PAR:  st_q <= ST_STOP;
            default: st_q <= ST_IDLE;
         endcase
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_comb begin
      unique case (st_q)
         ST_START: line = 1'b0;
         ST_DATA:  line = sh_q[0];
         ST_PAR:   line = par_q;
         default:  line = 1'b1;
      endcase
   end

   assign txd_o   = brk_i ? 1'b0 : line;
   assign ready_o = (st_q == ST_IDLE);
   assign empty_o = (st_q == ST_IDLE);
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
   import uart_fe_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       len_i,
   input  logic             par_en_i,
   input  logic             even_i,
   input  logic             stick_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             rxd_i,
   output logic [7:0]       data_o,
   output logic             valid_o,
   output logic             perr_o,
   output logic             ferr_o,
   output logic             brk_o
);
   localparam int CNT_W = DIV_W + 2;

   logic             rx_s, prev_q, seen_q, par_s_q;
   fe_state_t        st_q;
   logic [CNT_W-1:0] cnt_q, period_q, lim;
   logic [7:0]       sh_q, word;
   logic [2:0]       bit_q;
   logic [1:0]       len_q;
   logic             par_en_q, even_q, stick_q;

   uart_fe_sync #(.STAGES(SYNC_N)) i_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
   );

   assign lim  = (st_q == ST_START) ? (period_q >> 1) : period_q;
   assign word = sh_q >> (2'd3 - len_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         prev_q   <= 1'b1;
         cnt_q    <= '0;
         period_q <= CNT_W'(2);
         sh_q     <= '0;
         bit_q    <= '0;
         len_q    <= '0;
         par_en_q <= 1'b0;
         even_q   <= 1'b0;
         stick_q  <= 1'b0;
         seen_q   <= 1'b0;
         par_s_q  <= 1'b0;
         data_o   <= '0;
         valid_o  <= 1'b0;
         perr_o   <= 1'b0;
         ferr_o   <= 1'b0;
         brk_o    <= 1'b0;
      end else begin
         prev_q  <= rx_s;
         valid_o <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (prev_q && !rx_s) begin
               len_q    <= len_i;
               par_en_q <= par_en_i;
               even_q   <= even_i;
               stick_q  <= stick_i;
               period_q <= {2'b00, div_i} + CNT_W'(2);
               cnt_q    <= '0;
               seen_q   <= 1'b0;
               st_q     <= ST_START;
            end
         end else if (cnt_q == lim - CNT_W'(1)) begin
            cnt_q <= '0;
            unique case (st_q)
               ST_START: begin
                  bit_q <= '0;
                  sh_q  <= '0;
                  st_q  <= rx_s ? ST_IDLE : ST_DATA;
               end
               ST_DATA: begin
                  sh_q   <= {rx_s, sh_q[7:1]};
                  seen_q <= seen_q | rx_s;
                  if (bit_q == {1'b1, len_q}) st_q <= par_en_q ? ST_PAR : ST_STOP;
                  else                        bit_q <= bit_q + 3'd1;
               end
               ST_PAR: begin
                  par_s_q <= rx_s;
                  seen_q  <= seen_q | rx_s;
                  st_q    <= ST_STOP;
               end
               default: begin
                  data_o  <= word;
                  valid_o <= 1'b1;
                  perr_o  <= par_en_q && (par_s_q != fe_parity(stick_q, even_q, len_q, word));
                  ferr_o  <= !rx_s;
                  brk_o   <= !rx_s && !seen_q;
                  st_q    <= ST_IDLE;
               end
            endcase
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
   parameter int DIV_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [6:0]       lcr_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [7:0]       tx_data_i,
   input  logic             tx_valid_i,
   output logic             tx_ready_o,
   output logic             txd_o,
   output logic             tx_empty_o,
   input  logic             rxd_i,
   output logic [7:0]       rx_data_o,
   output logic             rx_valid_o,
   output logic             rx_perr_o,
   output logic             rx_ferr_o,
   output logic             rx_brk_o
);
   if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
      $error("DIV_W out of range");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end

   uart_fe_tx #(.DIV_W(DIV_W)) i_tx (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .len_i(lcr_i[1:0]), .long_stop_i(lcr_i[2]), .par_en_i(lcr_i[3]),
      .even_i(lcr_i[4]), .stick_i(lcr_i[5]), .brk_i(lcr_i[6]),
      .div_i(div_i), .data_i(tx_data_i), .valid_i(tx_valid_i),
      .ready_o(tx_ready_o), .txd_o(txd_o), .empty_o(tx_empty_o)
   );

   uart_fe_rx #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) i_rx (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .len_i(lcr_i[1:0]), .par_en_i(lcr_i[3]), .even_i(lcr_i[4]),
      .stick_i(lcr_i[5]), .div_i(div_i), .rxd_i(rxd_i),
      .data_o(rx_data_o), .valid_o(rx_valid_o), .perr_o(rx_perr_o),
      .ferr_o(rx_ferr_o), .brk_o(rx_brk_o)
   );
endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic lcr_brk,
   input logic tx_valid_i,
   input logic tx_ready_o,
   input logic txd_o,
   input logic tx_empty_o,
   input logic rx_valid_o,
   input logic rx_brk_o,
   input logic rx_ferr_o
);
   AST_BREAK_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lcr_brk |-> !txd_o); // R5
   AST_ACCEPT_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_valid_i && tx_ready_o) |=> !tx_empty_o); // R7
   AST_EMPTY_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_empty_o && !lcr_brk) |-> txd_o); // R7
   AST_NO_READY_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tx_empty_o |-> !tx_ready_o); // R8
   AST_BREAK_IMPLIES_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_o && rx_brk_o) |-> rx_ferr_o); // R11
   AST_RX_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o |=> !rx_valid_o); // R12
endmodule

bind uart_frame_engine uart_frame_engine_chk i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .lcr_brk(lcr_i[6]),
   .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .txd_o(txd_o),
   .tx_empty_o(tx_empty_o), .rx_valid_o(rx_valid_o),
   .rx_brk_o(rx_brk_o), .rx_ferr_o(rx_ferr_o)
);

// File: tb/test_uart_frame_engine.sv
`timescale 1ns/1ps
module test_uart_frame_engine;
   localparam int DIV_W = 16;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic [6:0]       lcr = 7'b0000011;
   logic [DIV_W-1:0] div = 16'd8;
   logic [7:0]       tx_data = '0;
   logic             tx_valid = 1'b0, rxd = 1'b1;
   logic             tx_ready, txd, tx_empty, rx_valid, rx_perr, rx_ferr, rx_brk;
   logic [7:0]       rx_data;

   int n_chk = 0, n_fail = 0;
   logic mon_on = 1'b0;
   logic [8:0]  tx_exp_q[$];   // {parity, data}
   logic [10:0] rx_exp_q[$];   // {brk, ferr, perr, data}

   always #5 clk = ~clk;

   uart_frame_engine #(.DIV_W(DIV_W)) i_uart_frame_engine (
      .clk_i(clk), .rst_ni(rst_n), .lcr_i(lcr), .div_i(div),
      .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
      .txd_o(txd), .tx_empty_o(tx_empty), .rxd_i(rxd), .rx_data_o(rx_data),
      .rx_valid_o(rx_valid), .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr),
      .rx_brk_o(rx_brk)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int per();
      return int'(div) + 2;
   endfunction
   function automatic int nbits();
      return 5 + int'(lcr[1:0]);
   endfunction
   function automatic logic [7:0] msk(input logic [7:0] d);
      return d & (8'hFF >> (3 - lcr[1:0]));
   endfunction
   function automatic logic epar(input logic [7:0] d);
      if (lcr[5]) return lcr[4] ? 1'b0 : 1'b1;
      return lcr[4] ? ^msk(d) : ~^msk(d);
   endfunction
   function automatic int frame_len();
      int stop;
      if (!lcr[2])          stop = per();
      else if (nbits() == 5) stop = per() + per() / 2;
      else                  stop = 2 * per();
      return per() * (1 + nbits() + (lcr[3] ? 1 : 0)) + stop;
   endfunction

   task automatic send_tx(input logic [7:0] d, input string req);
      int n;
      tx_exp_q.push_back({epar(d), msk(d)});
      @(negedge clk);
      chk(tx_ready === 1'b1, "R8 ready when idle", tx_ready, 1);
      tx_data  = d;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_empty === 1'b0 && tx_ready === 1'b0, "R7 busy after accept", tx_empty, 0);
      n = 0;
      while (tx_empty !== 1'b1) begin
         @(negedge clk);
         n++;
      end
      chk(n == frame_len(), req, n, frame_len());
      repeat (3) @(negedge clk);
   endtask

   task automatic drive_bit(input logic b, input int cycles);
      rxd = b;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic send_rx(input logic [7:0] d, input logic bad_par, input logic bad_stop);
      logic p;
      p = epar(d) ^ bad_par;
      rx_exp_q.push_back({1'b0, bad_stop, bad_par & lcr[3], msk(d)});
      @(negedge clk);
      drive_bit(1'b0, per());
      for (int i = 0; i < nbits(); i++) drive_bit(d[i], per());
      if (lcr[3]) drive_bit(p, per());
      if (bad_stop) drive_bit(1'b0, per());
      drive_bit(1'b1, 3 * per());
   endtask

   // TX monitor: decodes the line on its own and pops the expected item
   initial begin
      logic prev;
      logic [7:0] d;
      logic p, s;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (mon_on && prev && !txd) begin
            repeat (per() / 2) @(negedge clk);
            chk(txd === 1'b0, "R9 tx start bit low at mid", txd, 0);
            d = '0;
            p = 1'b0;
            for (int i = 0; i < nbits(); i++) begin
               repeat (per()) @(negedge clk);
               d[i] = txd;
            end
            if (lcr[3]) begin
               repeat (per()) @(negedge clk);
               p = txd;
            end
            repeat (per()) @(negedge clk);
            s = txd;
            if (tx_exp_q.size() == 0) chk(1'b0, "R8 unexpected tx frame", d, 0);
            else begin
               logic [8:0] e;
               e = tx_exp_q.pop_front();
               chk(d == e[7:0], "R1 tx data LSB first", d, e[7:0]);
               if (lcr[3]) chk(p == e[8], "R3/R4 tx parity bit", p, e[8]);
               chk(s === 1'b1, "R2 tx stop bit high", s, 1);
            end
         end
         prev = txd;
      end
   end

   // RX monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rx_valid === 1'b1) begin
            if (rx_exp_q.size() == 0) chk(1'b0, "R9 unexpected rx char", rx_data, 0);
            else begin
               logic [10:0] e;
               e = rx_exp_q.pop_front();
               chk(rx_data == e[7:0], "R1 rx data", rx_data, e[7:0]);
               chk(rx_perr == e[8], "R3 rx parity flag", rx_perr, e[8]);
               chk(rx_ferr == e[9], "R10 rx framing flag", rx_ferr, e[9]);
               chk(rx_brk == e[10], "R11 rx break flag", rx_brk, e[10]);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(txd === 1'b1 && tx_empty === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0,
          "R7 reset state", {txd, tx_empty, tx_ready, rx_valid}, 4'b1110);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_on = 1'b1;

      // R6 8N1, period 10
      lcr = 7'b0000011; div = 16'd8;
      send_tx(8'hA5, "R6 8N1 frame length");
      send_tx(8'h3C, "R6 8N1 frame length");
      // R2 5-bit, 1.5 stop, odd period 13
      lcr = 7'b0000100; div = 16'd11;
      send_tx(8'h16, "R2 5-bit 1.5 stop frame length");
      // R3 7-bit even parity, 2 stop
      lcr = 7'b0011110; div = 16'd8;
      send_tx(8'h5B, "R2 7E2 frame length");
      // R4 stick parity, odd select -> 1 then even select -> 0
      lcr = 7'b0101001;
      send_tx(8'h2A, "R4 stick odd frame length");
      lcr = 7'b0111001;
      send_tx(8'h2B, "R4 stick even frame length");

      // R5 forced break
      mon_on = 1'b0;
      @(negedge clk);
      lcr[6] = 1'b1;
      repeat (5) @(negedge clk);
      chk(txd === 1'b0, "R5 break holds TX low", txd, 0);
      lcr[6] = 1'b0;
      @(negedge clk);
      chk(txd === 1'b1, "R5 TX high after break cleared", txd, 1);
      repeat (3) @(negedge clk);
      mon_on = 1'b1;

      // receiver
      lcr = 7'b0000011; div = 16'd8;
      send_rx(8'hC3, 1'b0, 1'b0);
      lcr = 7'b0001001;  // 6-bit odd
      send_rx(8'h15, 1'b0, 1'b0);
      send_rx(8'h15, 1'b1, 1'b0);    // R3 parity error
      lcr = 7'b0011110;  // 7E2
      send_rx(8'h5B, 1'b0, 1'b0);
      lcr = 7'b0101001;  // 6-bit stick odd: expect 1
      send_rx(8'h0F, 1'b1, 1'b0);    // R4 stick parity error
      lcr = 7'b0000011; div = 16'd11;
      send_rx(8'h81, 1'b0, 1'b1);    // R10 framing error
      // R11 break on the line
      rx_exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
      @(negedge clk);
      drive_bit(1'b0, 11 * per());
      drive_bit(1'b1, 3 * per());
      // R9 short start glitch, then a clean character
      div = 16'd8;
      drive_bit(1'b0, 2);
      drive_bit(1'b1, 3 * per());
      chk(rx_exp_q.size() == 0, "R9 glitch gives no character", rx_exp_q.size(), 0);
      send_rx(8'h7E, 1'b0, 1'b0);

      repeat (50) @(negedge clk);
      chk(rx_exp_q.size() == 0, "R12 all rx chars seen", rx_exp_q.size(), 0);
      chk(tx_exp_q.size() == 0, "R1 all tx frames seen", tx_exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule